// File: doc/BRIEF.md
# Endian-Aware Byte Lane Steering

This block sits between a processor load/store port and a 32-bit memory data bus. Each request carries a byte address, an access size, a byte-order mode, a signed-load flag and store data. The request is registered once. From that registered copy the block derives the word address, four active-low byte enables, store data replicated across the lanes, and the load value taken out of the returned bus word. A single datapath serves both byte orders, and the mode can change on every request.

The request interface is a valid-only stream. The block has no back-pressure: it takes a request on every cycle that `req_valid` is high. Each request produces exactly one result cycle one clock later. That result is either a bus transfer (`bus_valid`) or an alignment error (`misalign`). A misaligned access is never split into several transfers. It is refused. The data path uses a fixed lane wiring. Byte enable `bus_be_n[j]` guards bus bits `8j+7:8j`. In little-endian mode, byte offset `o` inside the word uses lane `o`. In big-endian mode it uses lane `3-o`. The result is that a big-endian halfword at offset 2, or a word at offset 0, already sits in the low bits of the bus in register order.

Top module: `endian_lane_steer`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first request, `bus_valid` and `misalign` are 0 and `bus_be_n` is 4'hF.
- R2: A request presented with `req_valid` high at a rising edge sets exactly one of `bus_valid` or `misalign` for the following cycle. A cycle with no request leaves both low and `bus_be_n` at 4'hF.
- R3: During a transfer, `bus_word_addr` equals bits 31:2 of the request address.
- R4: Size encoding is 0 = byte, 1 = halfword, 2 = word, 3 = reserved. A halfword with address bit 0 set, a word with either of address bits 1:0 set, or any reserved-size request is misaligned. A misaligned request raises `misalign`, keeps `bus_valid` low and `bus_be_n` at 4'hF, and drives `ld_data` to 0.
- R5: In little-endian mode (`req_big_endian`=0), the byte at word offset o uses lane o. A halfword at offset 0 enables lanes 0 and 1, a halfword at offset 2 enables lanes 2 and 3, and a word enables all four. Lane j is bus bits 8j+7:8j and is enabled when `bus_be_n[j]`=0.
- R6: In big-endian mode (`req_big_endian`=1), the byte at word offset o uses lane 3-o. A halfword at offset 0 enables lanes 3 and 2, and a halfword at offset 2 enables lanes 1 and 0.
- R7: Store data on the bus is the operand's low byte replicated four times for a byte access, the low halfword replicated twice for a halfword access, and the full operand for a word access. This applies to enabled and disabled lanes alike.
- R8: The load result is the enabled lanes of `bus_rdata`, shifted right so that the lowest enabled lane lands in bits 7:0. As a result, big-endian mode returns the byte at the lowest address as the most significant byte.
- R9: For byte and halfword loads, the upper bits are zero when `req_signed`=0. When `req_signed`=1 they are copies of bit 7 (byte) or bit 15 (halfword). Word loads are not extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | Access size code |
| req_big_endian | input | 1 | 1 = big-endian byte order |
| req_signed | input | 1 | Sign-extend sub-word loads |
| req_wdata | input | 32 | Store operand, right-justified |
| bus_rdata | input | 32 | Word returned from the bus |
| bus_valid | output | 1 | Aligned transfer presented |
| misalign | output | 1 | Registered request was misaligned |
| bus_word_addr | output | 30 | Word address |
| bus_be_n | output | 4 | Active-low byte enables |
| bus_wdata | output | 32 | Lane-steered store data |
| ld_data | output | 32 | Extracted and extended load value |

## Verification
The assertions check the following on every cycle. A misaligned result has all enables high. Idle cycles enable no lane. Every result follows a request from the previous cycle. The word address tracks the request. The number of enabled lanes matches the access size. Byte stores are replicated. Only the bench's sweep over every mode, size, offset and sign choice can show which lanes are chosen, how the load value is extracted, and how it is extended. The bench checks these against byte-by-byte address arithmetic done in the bench itself.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/lane_align_check.sv
module lane_align_check
  import lane_steer_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic [OFF_W-1:0] off_i,
  input  acc_size_e        size_i,
  output logic             err_o
);
  logic [OFF_W-1:0] low_mask;

  always_comb begin
    // bits of the offset that must be zero for a naturally aligned item
    low_mask = OFF_W'((1 << int'(size_i)) - 1);
    err_o    = (size_i == SZ_RSVD) || ((off_i & low_mask) != '0);
  end
endmodule

// File: rtl/lane_select.sv
module lane_select
  import lane_steer_pkg::*;
#(
  parameter int LANES = 4,
  parameter int OFF_W = 2
) (
  input  logic [OFF_W-1:0] off_i,
  input  acc_size_e        size_i,
  input  logic             big_i,
  output logic [OFF_W-1:0] low_lane_o,
  output logic [LANES-1:0] lane_mask_o
);
  int nbytes;
  int low;

  always_comb begin
    nbytes = 1 << int'(size_i);
    // big-endian mirrors the offset: lowest address lands on the top lane
    if (big_i) low = LANES - int'(off_i) - nbytes;
    else       low = int'(off_i);
    low_lane_o  = OFF_W'(low);
    lane_mask_o = LANES'(((1 << nbytes) - 1) << low_lane_o);
  end
endmodule

// File: rtl/lane_write_steer.sv
module lane_write_steer
  import lane_steer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  acc_size_e         size_i,
  input  logic [DATA_W-1:0] src_i,
  output logic [DATA_W-1:0] bus_o
);
  localparam int LANES = DATA_W / 8;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: bus_o = {LANES{src_i[7:0]}};
      SZ_HALF: bus_o = {(LANES/2){src_i[15:0]}};
      default: bus_o = src_i;
    endcase
  end
endmodule

// File: rtl/lane_read_extract.sv
module lane_read_extract
  import lane_steer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 2
) (
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [OFF_W-1:0]  low_lane_i,
  input  acc_size_e         size_i,
  input  logic              signed_i,
  output logic [DATA_W-1:0] val_o
);
  logic [DATA_W-1:0] shifted;

  always_comb begin
    shifted = rdata_i >> {low_lane_i, 3'b000};
    unique case (size_i)
      SZ_BYTE: val_o = {{(DATA_W-8){signed_i & shifted[7]}}, shifted[7:0]};
      SZ_HALF: val_o = {{(DATA_W-16){signed_i & shifted[15]}}, shifted[15:0]};
      default: val_o = shifted;
    endcase
  end
endmodule

// File: rtl/endian_lane_steer.sv
module endian_lane_steer
  import lane_steer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [1:0]              req_size,
  input  logic                    req_big_endian,
  input  logic                    req_signed,
  input  logic [DATA_W-1:0]       req_wdata,
  input  logic [DATA_W-1:0]       bus_rdata,
  output logic                    bus_valid,
  output logic                    misalign,
  output logic [ADDR_W-OFF_W-1:0] bus_word_addr,
  output logic [DATA_W/8-1:0]     bus_be_n,
  output logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       ld_data
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  // registered request
  logic              r_valid;
  logic [ADDR_W-1:0] r_addr;
  acc_size_e         r_size;
  logic              r_big;
  logic              r_signed;
  logic [DATA_W-1:0] r_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_valid  <= 1'b0;
      r_addr   <= '0;
      r_size   <= SZ_BYTE;
      r_big    <= 1'b0;
      r_signed <= 1'b0;
      r_wdata  <= '0;
    end else begin
      r_valid <= req_valid;
      if (req_valid) begin
        r_addr   <= req_addr;
        r_size   <= acc_size_e'(req_size);
        r_big    <= req_big_endian;
        r_signed <= req_signed;
        r_wdata  <= req_wdata;
      end
    end
  end

  logic [OFF_W-1:0] off;
  logic             err;
  logic [OFF_W-1:0] low_lane;
  logic [LANES-1:0] lane_mask;
  logic [DATA_W-1:0] steered;
  logic [DATA_W-1:0] extracted;

  assign off = r_addr[OFF_W-1:0];

  lane_align_check #(.OFF_W(OFF_W)) u_align (
    .off_i  (off),
    .size_i (r_size),
    .err_o  (err)
  );

  lane_select #(.LANES(LANES), .OFF_W(OFF_W)) u_sel (
    .off_i       (off),
    .size_i      (r_size),
    .big_i       (r_big),
    .low_lane_o  (low_lane),
    .lane_mask_o (lane_mask)
  );

  lane_write_steer #(.DATA_W(DATA_W)) u_wr (
    .size_i (r_size),
    .src_i  (r_wdata),
    .bus_o  (steered)
  );

  lane_read_extract #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_rd (
    .rdata_i    (bus_rdata),
    .low_lane_i (low_lane),
    .size_i     (r_size),
    .signed_i   (r_signed),
    .val_o      (extracted)
  );

  always_comb begin
    bus_valid     = r_valid & ~err;
    misalign      = r_valid & err;
    bus_word_addr = r_addr[ADDR_W-1:OFF_W];
    bus_be_n      = bus_valid ? ~lane_mask : '1;
    bus_wdata     = steered;
    ld_data       = bus_valid ? extracted : '0;
  end
endmodule

// File: rtl/lane_steer_checker.sv
module lane_steer_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] req_addr,
  input logic [1:0]  req_size,
  input logic        bus_valid,
  input logic        misalign,
  input logic [29:0] bus_word_addr,
  input logic [3:0]  bus_be_n,
  input logic [31:0] bus_wdata
);
  a_r4_misalign_no_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (bus_be_n == 4'hF && !bus_valid));

  a_r2_idle_no_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> bus_be_n == 4'hF);

  a_r2_result_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid || misalign) |-> $past(req_valid));

  a_r2_request_gives_result: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (bus_valid ^ misalign));

  a_r3_word_addr: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> bus_word_addr == $past(req_addr[31:2]));

  a_r5_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> $countones(~bus_be_n) == (1 << int'($past(req_size))));

  a_r7_byte_replicated: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && $past(req_size) == 2'd0) |-> bus_wdata == {4{bus_wdata[7:0]}});
endmodule

bind endian_lane_steer lane_steer_checker u_lane_steer_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_addr      (req_addr),
  .req_size      (req_size),
  .bus_valid     (bus_valid),
  .misalign      (misalign),
  .bus_word_addr (bus_word_addr),
  .bus_be_n      (bus_be_n),
  .bus_wdata     (bus_wdata)
);

// File: tb/test_endian_lane_steer.sv
module test_endian_lane_steer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_big_endian = 1'b0;
  logic        req_signed = 1'b0;
  logic [31:0] req_wdata = '0;
  logic [31:0] bus_rdata = '0;
  logic        bus_valid, misalign;
  logic [29:0] bus_word_addr;
  logic [3:0]  bus_be_n;
  logic [31:0] bus_wdata, ld_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  endian_lane_steer i_endian_lane_steer (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_case(input bit big, input int sz, input int off,
                          input bit sgn, input logic [31:0] wd, input logic [31:0] rd,
                          input logic [29:0] wa);
    int n;
    bit bad_align;
    logic [3:0]  exp_be;
    logic [31:0] exp_wd, exp_ld;
    @(negedge clk);
    req_valid      = 1'b1;
    req_addr       = {wa, 2'(off)};
    req_size       = 2'(sz);
    req_big_endian = big;
    req_signed     = sgn;
    req_wdata      = wd;
    bus_rdata      = rd;
    n = 1 << sz;
    bad_align = (sz == 3) || ((off % n) != 0);
    exp_be = 4'hF;
    exp_ld = '0;
    if (!bad_align) begin
      // walk the item byte by byte in address order
      for (int k = 0; k < n; k++) begin
        int lane, rb;
        lane = big ? 3 - (off + k) : off + k;
        rb   = big ? n - 1 - k : k;
        exp_be[lane] = 1'b0;
        exp_ld[8*rb +: 8] = rd[8*lane +: 8];
      end
      if (sgn && n < 4 && exp_ld[8*n-1])
        for (int b = 8*n; b < 32; b++) exp_ld[b] = 1'b1;
    end
    exp_wd = (sz == 0) ? {4{wd[7:0]}} : (sz == 1) ? {2{wd[15:0]}} : wd;
    @(negedge clk);
    chk("R4 misalign", 32'(misalign), 32'(bad_align));
    chk("R2 bus_valid", 32'(bus_valid), 32'(!bad_align));
    chk(big ? "R6 byte enables" : "R5 byte enables", 32'(bus_be_n), 32'(exp_be));
    chk("R8 R9 load value", ld_data, exp_ld);
    if (!bad_align) begin
      chk("R3 word address", 32'(bus_word_addr), 32'(wa));
      chk("R7 store data", bus_wdata, exp_wd);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 32'(bus_valid), 32'd0);
    chk("R1 be_n in reset", 32'(bus_be_n), 32'hF);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 misalign after reset", 32'(misalign), 32'd0);
    chk("R2 idle be_n", 32'(bus_be_n), 32'hF);
    for (int big = 0; big < 2; big++)
      for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 4; off++)
          for (int sgn = 0; sgn < 2; sgn++) begin
            run_case(big[0], sz, off, sgn[0], 32'hA1B2C3D4, 32'h8F7E6D5C, 30'h0ABCDEF1);
            run_case(big[0], sz, off, sgn[0], 32'h13579BDF, 32'h7F80FF01, 30'h3FFFFFFF);
          end
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R2 idle after traffic valid", 32'(bus_valid), 32'd0);
    chk("R2 idle after traffic be_n", 32'(bus_be_n), 32'hF);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule